// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Generator

This block is the status side of a parallel NOR flash controller. It watches host write cycles and counts the unlock and command writes that start a program or a sector erase. It tracks the operating mode: idle, programming, erasing, erase suspended for reads, and programming inside an erase suspend. The cell array and the embedded algorithms are not modelled. A single `op_done` pulse stands in for the end of an embedded operation.

The block drives an active-low ready/busy line as an open-drain style enable (`busy_pull_en`). When it is high the line is pulled low, and the board ties it to a pull-up. Each host read strobe returns a status byte. That byte carries a general toggle bit on bit 6 and a sector-sensitive toggle bit on bit 2. Together they let the host tell a running operation apart from an erase suspend, and find which sector is being erased.

A command sequence starts with 0xAA written at low address 0x555 and 0x55 written at low address 0x2AA. The next write selects the command. 0xA0 at 0x555 is followed by one data write. 0x80 at 0x555 is followed by 0xAA at 0x555, 0x55 at 0x2AA and 0x30 at the target sector. Writing 0xB0 during an erase suspends it. Writing 0x30 in suspend resumes it. The sector is the top `SECT_W` bits of the address.

Top module: `flash_status_flags`

## Requirements
- R1: A program sequence makes the block busy in the cycle after its 4th write (the data write). After only three writes it is still ready.
- R2: An erase sequence makes the block busy in the cycle after its 6th write (0x30), and it records that write's sector as the erasing sector. After five writes it is still ready.
- R3: Writing 0xB0 while erasing enters erase-suspend-read, and the block reads ready. Writing 0x30 in erase-suspend-read resumes the erase, and the block is busy again.
- R4: `busy_pull_en` is high whenever `rst_n` is low. After reset the block is idle and ready, and both toggle bits are 0.
- R5: While busy, command writes are ignored. A full erase sequence issued during a program starts nothing.
- R6: While erasing, each read from the erasing sector inverts bit 2. Reads from other sectors leave bit 2 unchanged.
- R7: In erase-suspend-read, each read from the suspended sector inverts bit 2. Bit 6 does not change.
- R8: In suspend-program, a read from a sector other than the suspended one returns 1 on bit 2. A read from the suspended sector returns the held bit 2 value.
- R9: Bit 6 inverts on each read while programming, erasing or in suspend-program. In idle it holds its value. All status bits other than 6 and 2 read 0.
- R10: `op_done` during a program or erase returns the block to idle and ready, and both toggle bits keep their values. `op_done` during suspend-program returns the block to erase-suspend-read.
- R11: A write that does not match the expected unlock step sends the sequence back to its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| rd_stb | input | 1 | Host status read strobe, one cycle per read |
| addr | input | ADDR_W | Host address; top SECT_W bits select the sector |
| wr_data | input | DATA_W | Host write data (command byte) |
| op_done | input | 1 | End-of-operation pulse from the embedded algorithm stub |
| rd_data | output | DATA_W | Status byte from the last read (bit 6 general toggle, bit 2 sector toggle) |
| busy_pull_en | output | 1 | High pulls the open-drain ready/busy line low (busy) |

## Verification
The assertions check several rules on every cycle. The ready/busy enable is held high in reset and in busy modes, and is released in erase-suspend-read. A command walk never advances while the block is busy. The general toggle bit never moves without a read, or on a read in idle or suspend-read. The write counts that start a program or an erase, and the sector-dependent toggling, are shown by the bench. It runs directed and randomly mixed read sequences across sectors, and compares each status byte with a reference model built from the requirements.

// File: rtl/flash_status_flags.sv
module flash_status_flags #(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy_pull_en
);

  localparam int GEN_BIT = 6;
  localparam int SEC_BIT = 2;
  localparam logic [10:0] UNL_A = 11'h555;
  localparam logic [10:0] UNL_B = 11'h2AA;
  localparam logic [DATA_W-1:0] K_AA   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] K_55   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] K_PROG = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] K_ERS  = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] K_GO   = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] K_SUSP = DATA_W'(8'hB0);

  typedef enum logic [2:0] {M_IDLE, M_PROG, M_ERASE, M_SRD, M_SPROG} mode_t;
  typedef enum logic [2:0] {C_U1, C_U2, C_CMD, C_PDAT, C_E1, C_E2, C_ESEC} step_t;

  mode_t mode;
  step_t step;
  logic [SECT_W-1:0] esect;
  logic tog_g, tog_s;

  wire [SECT_W-1:0] sect = addr[ADDR_W-1 -: SECT_W];
  wire at_a = (addr[10:0] == UNL_A);
  wire at_b = (addr[10:0] == UNL_B);
  wire busy = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_SPROG);
  wire hit  = (sect == esect);

  wire g_nxt = busy ? ~tog_g : tog_g;
  wire s_nxt = (((mode == M_ERASE) || (mode == M_SRD)) && hit) ? ~tog_s : tog_s;
  wire s_out = ((mode == M_SPROG) && !hit) ? 1'b1 : s_nxt;

  assign busy_pull_en = !rst_n || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_IDLE;
      step  <= C_U1;
      esect <= '0;
    end else if (op_done) begin
      step <= C_U1;
      case (mode)
        M_PROG, M_ERASE: mode <= M_IDLE;
        M_SPROG:         mode <= M_SRD;
        default:         mode <= mode;
      endcase
    end else if (wr_stb) begin
      if (mode == M_ERASE) begin
        if (wr_data == K_SUSP) mode <= M_SRD;
      end else if (!busy) begin
        if (mode == M_SRD && step == C_U1 && wr_data == K_GO) begin
          mode <= M_ERASE;
        end else begin
          case (step)
            C_U1:  step <= (at_a && wr_data == K_AA) ? C_U2 : C_U1;
            C_U2:  step <= (at_b && wr_data == K_55) ? C_CMD : C_U1;
            C_CMD: begin
              if (at_a && wr_data == K_PROG) step <= C_PDAT;
              else if (at_a && wr_data == K_ERS && mode == M_IDLE) step <= C_E1;
              else step <= C_U1;
            end
            C_PDAT: begin
              step <= C_U1;
              mode <= (mode == M_SRD) ? M_SPROG : M_PROG;
            end
            C_E1:  step <= (at_a && wr_data == K_AA) ? C_E2 : C_U1;
            C_E2:  step <= (at_b && wr_data == K_55) ? C_ESEC : C_U1;
            C_ESEC: begin
              step <= C_U1;
              if (wr_data == K_GO) begin
                mode  <= M_ERASE;
                esect <= sect;
              end
            end
            default: step <= C_U1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_g   <= 1'b0;
      tog_s   <= 1'b0;
      rd_data <= '0;
    end else if (rd_stb) begin
      tog_g   <= g_nxt;
      tog_s   <= s_nxt;
      rd_data <= '0;
      rd_data[GEN_BIT] <= g_nxt;
      rd_data[SEC_BIT] <= s_out;
    end
  end

  p_prog_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !op_done && mode == M_IDLE && step == C_PDAT) |=> (mode == M_PROG && busy_pull_en));

  p_erase_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !op_done && step == C_ESEC && wr_data == K_GO && !busy) |=> (mode == M_ERASE && esect == $past(sect)));

  p_susp_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SRD) |-> !busy_pull_en);

  p_reset_busy_r4: assert property (@(posedge clk)
    !rst_n |-> busy_pull_en);

  p_no_cmd_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step == C_U1));

  p_gen_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb || mode == M_SRD || mode == M_IDLE) |=> $stable(tog_g));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (mode == M_PROG || mode == M_ERASE)) |=> (mode == M_IDLE && !busy_pull_en));

endmodule

// File: tb/flash_status_flags_test.sv
`timescale 1ns/1ps
module flash_status_flags_test;
  localparam int AW = 18, SW = 3, DW = 8;

  logic clk = 0, rst_n = 0, wr_stb = 0, rd_stb = 0, op_done = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy_pull_en;
  wire ready_line = busy_pull_en ? 1'b0 : 1'b1;

  int checks = 0, fails = 0;
  int m = 0;
  logic [SW-1:0] es = '0;
  logic eg = 0, esec = 0;
  bit finished = 0;

  flash_status_flags #(.ADDR_W(AW), .SECT_W(SW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wr_data(wr_data), .op_done(op_done), .rd_data(rd_data), .busy_pull_en(busy_pull_en));

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] mk(input logic [SW-1:0] s, input logic [10:0] lo);
    return {s, {(AW-SW-11){1'b0}}, lo};
  endfunction

  function automatic bit m_busy(input int mm);
    return mm == 1 || mm == 2 || mm == 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rdy(input string req);
    chk(ready_line == !m_busy(m), req, ready_line, !m_busy(m));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_stb = 1; addr = a; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(input logic [SW-1:0] s, input string req);
    logic [DW-1:0] exp;
    logic b2;
    @(negedge clk); rd_stb = 1; addr = mk(s, 11'h010);
    @(negedge clk); rd_stb = 0;
    if (m_busy(m)) eg = ~eg;
    if ((m == 2 || m == 3) && s == es) esec = ~esec;
    b2 = (m == 4 && s != es) ? 1'b1 : esec;
    exp = '0; exp[6] = eg; exp[2] = b2;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
    if (m == 1 || m == 2) m = 0; else if (m == 4) m = 3;
  endtask

  task automatic unlock();
    wr(mk(0, 11'h555), 8'hAA);
    wr(mk(0, 11'h2AA), 8'h55);
  endtask

  task automatic prog_seq(input logic [SW-1:0] s);
    unlock();
    wr(mk(0, 11'h555), 8'hA0);
    chk(ready_line == !m_busy(m), "R1 three writes", ready_line, !m_busy(m));
    wr(mk(s, 11'h123), 8'h5A);
    if (m == 0) m = 1; else if (m == 3) m = 4;
    chk_rdy("R1 busy after 4th write");
  endtask

  task automatic erase_seq(input logic [SW-1:0] s);
    unlock();
    wr(mk(0, 11'h555), 8'h80);
    unlock();
    chk(ready_line == !m_busy(m), "R2 five writes", ready_line, !m_busy(m));
    wr(mk(s, 11'h000), 8'h30);
    if (m == 0) begin m = 2; es = s; end
    chk_rdy("R2 busy after 6th write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy_pull_en == 1'b1, "R4 busy in reset", busy_pull_en, 1);
    rst_n = 1;
    @(negedge clk);
    chk_rdy("R4 ready after reset");
    rd(3'd0, "R4 R9 idle toggles zero");
    rd(3'd0, "R9 idle holds");

    unlock();
    wr(mk(0, 11'h2AA), 8'h12);
    wr(mk(0, 11'h555), 8'hA0);
    wr(mk(1, 11'h100), 8'h77);
    chk_rdy("R11 broken sequence starts nothing");

    prog_seq(3'd2);
    for (int i = 0; i < 5; i++) rd(3'($urandom_range(0, 7)), "R9 program toggles");
    erase_seq(3'd4);
    chk_rdy("R5 still program");
    done_pulse();
    chk_rdy("R10 R5 ready after done");
    rd(3'd4, "R10 R5 toggles hold after done");

    erase_seq(3'd5);
    for (int i = 0; i < 10; i++) rd(3'($urandom_range(0, 7)), "R6 R9 erase reads");
    rd(3'd5, "R6 erasing sector"); rd(3'd1, "R6 other sector");
    wr(mk(2, 11'h000), 8'hB0); m = 3;
    chk_rdy("R3 suspend ready");
    for (int i = 0; i < 8; i++) rd(3'($urandom_range(0, 7)), "R7 suspend read");
    rd(3'd5, "R7 suspended sector");
    prog_seq(3'd1);
    rd(3'd1, "R8 other sector reads one");
    rd(3'd5, "R8 suspended sector holds");
    for (int i = 0; i < 4; i++) rd(3'($urandom_range(0, 7)), "R8 R9 suspend program");
    done_pulse();
    chk_rdy("R10 back to suspend read");
    rd(3'd5, "R7 after suspend program");
    wr(mk(0, 11'h000), 8'h30); m = 2;
    chk_rdy("R3 resume busy");
    rd(3'd5, "R6 resumed erase");
    done_pulse();
    chk_rdy("R10 erase done");

    for (int k = 0; k < 30; k++) begin
      if ($urandom_range(0, 1) == 1) erase_seq(3'($urandom_range(0, 7)));
      else prog_seq(3'($urandom_range(0, 7)));
      for (int i = 0; i < 6; i++) rd(3'($urandom_range(0, 7)), "R6 R9 random reads");
      if (m == 2 && $urandom_range(0, 1) == 1) begin
        wr(mk(0, 11'h000), 8'hB0); m = 3;
        chk_rdy("R3 random suspend");
        for (int i = 0; i < 4; i++) rd(3'($urandom_range(0, 7)), "R7 random reads");
        wr(mk(0, 11'h000), 8'h30); m = 2;
        chk_rdy("R3 random resume");
      end
      done_pulse();
      chk_rdy("R10 random done");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule